// File: doc/BRIEF.md
# Phase-Cut Dimmer Detector and Run-Window Controller

This block sits in the digital core of an offline LED driver and works out what kind of phase-cut dimmer, if any, feeds the lamp. Its input is a sampled comparator bit that is high when rectified line voltage is present, together with a one-cycle strobe that marks the start of every half cycle. In each half cycle it counts the period and the ticks without line voltage. It notes whether the line was missing at the first tick, and it converts the missing share into a cut angle in whole degrees with an 8-step restoring divider.

The angle sets how long the power converter may switch. Below 40 degrees the converter runs whenever the line is present. From 40 to 140 degrees the run time falls linearly to zero. Above that, the converter stays off. A trailing-edge dimmer looks narrower than it is, because the input filter stores energy, so its measured angle is raised by a fixed offset before the mapping. When no dimmer is seen, the converter runs through the whole half cycle and the input looks resistive. An auxiliary current sink is enabled whenever line voltage is present and the converter is idle, so the dimmer keeps its holding current. Over-voltage and under-voltage flags override the run enable.

Top module: `phasecut_ctrl`

## Requirements
- R1: Each half cycle gets a candidate class. With ABSENT_MIN=8, fewer than 8 absent ticks gives "none". Otherwise, if line_ok was low at the strobe tick the class is leading edge, and if it was high the class is trailing edge.
- R2: The committed class changes only on a half-cycle strobe, and only after AGREE_N=4 consecutive half cycles give the same candidate. dimmer_present=1 means a dimmer is committed. dimmer_type=1 means trailing edge and 0 means leading edge; dimmer_type is 0 whenever dimmer_present is 0.
- R3: With no dimmer committed, run_en is high on every tick of the half cycle, whatever line_ok is.
- R4: The angle is floor(absent*180/period). With a dimmer committed and an effective angle of 40 or less, run_en equals line_ok.
- R5: For an effective angle strictly between 40 and 140, run_en is high only on the first floor(present*(140-angle)/100) ticks of the half cycle that have line_ok high.
- R6: For an effective angle of 140 or more, run_en stays low for the whole half cycle.
- R7: For a committed trailing-edge dimmer, the effective angle is the measured angle plus TE_OFFSET=10.
- R8: The window measured in half cycle k governs half cycle k+2.
- R9: sink_en = line_ok AND NOT run_en AND NOT uvlo.
- R10: While ovp is high, run_en is low.
- R11: While uvlo is high, run_en and sink_en are both low.
- R12: Out of reset the class is "none" and the window is empty. The block therefore starts in full-run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hc_start | input | 1 | One-tick strobe on the first tick of each half cycle |
| line_ok | input | 1 | Line voltage present comparator bit |
| ovp | input | 1 | Over-voltage flag, blocks the converter |
| uvlo | input | 1 | Supply below regulation, blocks converter and sink |
| run_en | output | 1 | Converter run enable |
| sink_en | output | 1 | Auxiliary current sink enable |
| dimmer_present | output | 1 | A dimmer is committed |
| dimmer_type | output | 1 | 1 trailing edge, 0 leading edge |

## Verification
The bench sweeps 0, 40, 90, 140 and 170 degrees for both dimmer types, plus random periods and cuts. This exposes an off-by-one at the 40 and 140 degree knees: such a design would clip one present tick too many or too few, or switch at full cut. A design that skipped the trailing-edge offset would run 40-degree trailing cuts at full width instead of a 90% window. Directed tests switch the pattern to check two things. The class must wait for four agreeing half cycles, where a hasty design flips after one. The window must lag exactly two half cycles, where a wrong pipeline applies the new window too early. Over-voltage and under-voltage tests confirm that the sink steps in, or stays off, while the converter is held down.

// File: rtl/phasecut_ctrl.sv
module phasecut_ctrl #(
  parameter int CW         = 16,
  parameter int ABSENT_MIN = 8,
  parameter int TE_OFFSET  = 10,
  parameter int LO_DEG     = 40,
  parameter int HI_DEG     = 140,
  parameter int AGREE_N    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hc_start,
  input  logic line_ok,
  input  logic ovp,
  input  logic uvlo,
  output logic run_en,
  output logic sink_en,
  output logic dimmer_present,
  output logic dimmer_type
);
  localparam int NW   = CW + 8;
  localparam int PW   = CW + 10;
  localparam int SPAN = HI_DEG - LO_DEG;
  localparam int AGW  = $clog2(AGREE_N + 1);
  localparam logic [1:0] C_NONE = 2'd0, C_LE = 2'd1, C_TE = 2'd2;

  logic [CW-1:0]  tcnt, acnt, pcnt, t_meas, a_meas, r_cur, r_pend;
  logic           first_ok, full_cur, full_pend;
  logic [1:0]     cls, last_cand, cand;
  logic [AGW-1:0] agree, agree_nx;
  logic [NW-1:0]  rem, dshift;
  logic [7:0]     quo;
  logic [2:0]     k;
  logic           busy, fin;

  assign cand = (acnt < CW'(ABSENT_MIN)) ? C_NONE : (first_ok ? C_TE : C_LE);
  assign agree_nx = (cand != last_cand) ? AGW'(1) :
                    (agree == AGW'(AGREE_N)) ? agree : agree + AGW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0; acnt <= '0; pcnt <= '0; first_ok <= 1'b0;
      cls <= C_NONE; last_cand <= C_NONE; agree <= '0;
    end else if (hc_start) begin
      tcnt      <= CW'(1);
      acnt      <= CW'(!line_ok);
      pcnt      <= CW'(line_ok);
      first_ok  <= line_ok;
      last_cand <= cand;
      agree     <= agree_nx;
      if (agree_nx == AGW'(AGREE_N)) cls <= cand;
    end else begin
      tcnt <= tcnt + CW'(1);
      acnt <= acnt + CW'(!line_ok);
      pcnt <= pcnt + CW'(line_ok);
    end
  end

  assign dshift = NW'(t_meas) << k;

  logic [9:0]    a_eff, diff;
  logic [CW-1:0] pc;
  logic [PW-1:0] prod;
  assign a_eff = {2'b0, quo} + ((cls == C_TE) ? 10'(TE_OFFSET) : 10'd0);
  assign diff  = 10'(HI_DEG) - a_eff;
  assign pc    = t_meas - a_meas;
  assign prod  = PW'(pc) * PW'(diff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_meas <= '0; a_meas <= '0; rem <= '0; quo <= '0; k <= '0;
      busy <= 1'b0; fin <= 1'b0;
      r_pend <= '0; full_pend <= 1'b0; r_cur <= '0; full_cur <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (hc_start) begin
        t_meas   <= tcnt;
        a_meas   <= acnt;
        rem      <= NW'(acnt) * NW'(180);
        quo      <= '0;
        k        <= 3'd7;
        busy     <= 1'b1;
        r_cur    <= r_pend;
        full_cur <= full_pend;
      end else if (busy) begin
        if (rem >= dshift) begin
          rem    <= rem - dshift;
          quo[k] <= 1'b1;
        end
        if (k == 3'd0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else k <= k - 3'd1;
      end else if (fin) begin
        full_pend <= (a_eff <= 10'(LO_DEG));
        if (a_eff >= 10'(HI_DEG)) r_pend <= '0;
        else r_pend <= CW'(prod / PW'(SPAN));
      end
    end
  end

  logic [CW-1:0] pidx;
  logic          win;
  assign pidx = hc_start ? '0 : pcnt;
  assign win  = full_cur ? line_ok : (line_ok && (pidx < r_cur));

  assign run_en         = ((cls == C_NONE) || win) && !ovp && !uvlo;
  assign sink_en        = line_ok && !run_en && !uvlo;
  assign dimmer_present = (cls != C_NONE);
  assign dimmer_type    = (cls == C_TE);
endmodule

// File: rtl/phasecut_ctrl_chk.sv
module phasecut_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hc_start,
  input logic line_ok,
  input logic ovp,
  input logic uvlo,
  input logic run_en,
  input logic sink_en,
  input logic dimmer_present,
  input logic dimmer_type
);
  p_ovp_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovp |-> !run_en);
  p_uvlo_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> (!run_en && !sink_en));
  p_sink_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sink_en |-> (line_ok && !run_en));
  p_nodim_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dimmer_present && !ovp && !uvlo) |-> run_en);
  p_dim_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dimmer_present && run_en) |-> line_ok);
  p_class_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dimmer_present, dimmer_type}) |-> $past(hc_start));
  p_type_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dimmer_type |-> dimmer_present);
endmodule

bind phasecut_ctrl phasecut_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hc_start(hc_start), .line_ok(line_ok),
  .ovp(ovp), .uvlo(uvlo), .run_en(run_en), .sink_en(sink_en),
  .dimmer_present(dimmer_present), .dimmer_type(dimmer_type));

// File: tb/tb_phasecut_ctrl.sv
`timescale 1ns/1ps
module tb_phasecut_ctrl;
  localparam int ABSENT_MIN = 8;
  localparam int TE_OFF     = 10;

  logic clk = 1'b0, rst_n = 1'b0, hc_start = 1'b0, line_ok = 1'b0;
  logic ovp = 1'b0, uvlo = 1'b1;
  logic run_en, sink_en, dimmer_present, dimmer_type;
  int   checks = 0, errors = 0;
  bit   ovp_b = 0, uvlo_b = 0, done = 0;

  phasecut_ctrl dut (.clk(clk), .rst_n(rst_n), .hc_start(hc_start), .line_ok(line_ok),
    .ovp(ovp), .uvlo(uvlo), .run_en(run_en), .sink_en(sink_en),
    .dimmer_present(dimmer_present), .dimmer_type(dimmer_type));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_window(input int T, input int C, input bit te);
    int a, ae;
    if (C < ABSENT_MIN) return -1;
    a  = (C * 180) / T;
    ae = a + (te ? TE_OFF : 0);
    if (ae <= 40) return T - C;
    if (ae >= 140) return 0;
    return ((T - C) * (140 - ae)) / 100;
  endfunction

  function automatic string region_tag(input int T, input int C, input bit te);
    int ae;
    if (C < ABSENT_MIN) return "R3";
    ae = (C * 180) / T + (te ? TE_OFF : 0);
    if (ae <= 40) return te ? "R4 R7" : "R4";
    if (ae >= 140) return te ? "R6 R7" : "R6";
    return te ? "R5 R7" : "R5";
  endfunction

  task automatic run_half(input int T, input int typ, input int C, input int exp_r,
                          input bit chk, input string tag);
    int pidx = 0, bad_r = 0, bad_s = 0, act_r = 0, exp_rc = 0, act_s = 0, exp_s = 0;
    for (int j = 0; j < T; j++) begin
      bit ln, er, es;
      @(negedge clk);
      ln = (typ == 1) ? (j >= C) : (typ == 2) ? (j < T - C) : 1'b1;
      line_ok = ln; hc_start = (j == 0); ovp = ovp_b; uvlo = uvlo_b;
      er = (exp_r < 0) ? 1'b1 : (ln && pidx < exp_r);
      if (ovp_b || uvlo_b) er = 1'b0;
      es = ln && !er && !uvlo_b;
      #2;
      if (run_en !== er) bad_r++;
      if (sink_en !== es) bad_s++;
      act_r += int'(run_en); exp_rc += int'(er);
      act_s += int'(sink_en); exp_s += int'(es);
      if (ln) pidx++;
    end
    if (chk) begin
      check(bad_r == 0, tag, act_r, exp_rc);
      check(bad_s == 0, "R9 sink", act_s, exp_s);
    end
  endtask

  task automatic steady(input int T, input int typ, input int C);
    bit te;
    int w;
    te = (typ == 2);
    w  = (typ == 0) ? -1 : exp_window(T, C, te);
    for (int h = 0; h < 7; h++) run_half(T, typ, C, w, 1'b0, "");
    run_half(T, typ, C, w, 1'b1, (typ == 0) ? "R3" : region_tag(T, C, te));
    check(dimmer_present == (typ != 0 && C >= ABSENT_MIN), "R1 present",
          int'(dimmer_present), int'(typ != 0 && C >= ABSENT_MIN));
    check(dimmer_type == (typ == 2 && C >= ABSENT_MIN), "R1 type",
          int'(dimmer_type), int'(typ == 2 && C >= ABSENT_MIN));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int angs[5] = '{0, 40, 90, 140, 170};
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    #2;
    check(!run_en && !sink_en, "R12 outputs", int'(run_en) + int'(sink_en), 0);
    check(!dimmer_present && !dimmer_type, "R12 class", int'(dimmer_present), 0);
    @(negedge clk); rst_n = 1'b1; uvlo = 1'b0; uvlo_b = 0; #2;
    check(run_en == 1'b1, "R12 full run", int'(run_en), 1);

    steady(360, 0, 0);
    foreach (angs[i]) for (int typ = 1; typ <= 2; typ++) steady(360, typ, angs[i] * 2);

    // R2: commit after four agreeing half cycles
    steady(360, 0, 0);
    for (int h = 0; h < 4; h++) run_half(360, 1, 180, -1, 1'b0, "");
    check(dimmer_present == 1'b0, "R2 before commit", int'(dimmer_present), 0);
    run_half(360, 1, 180, -1, 1'b0, "");
    check(dimmer_present == 1'b1 && dimmer_type == 1'b0, "R2 commit",
          int'(dimmer_present), 1);

    // R8: window lags two half cycles
    steady(360, 1, 180);
    run_half(360, 1, 280, 90, 1'b1, "R8 first");
    run_half(360, 1, 280, 90, 1'b1, "R8 second");
    run_half(360, 1, 280, 0, 1'b1, "R8 third");

    // R10, R11
    steady(360, 1, 180);
    ovp_b = 1; run_half(360, 1, 180, 90, 1'b1, "R10 ovp"); ovp_b = 0;
    run_half(360, 1, 180, 90, 1'b1, "R10 release");
    uvlo_b = 1; run_half(360, 1, 180, 90, 1'b1, "R11 uvlo"); uvlo_b = 0;
    run_half(360, 1, 180, 90, 1'b1, "R11 release");

    for (int n = 0; n < 10; n++) begin
      int T, typ, C;
      T   = 300 + int'($urandom % 121);
      typ = 1 + int'($urandom % 2);
      C   = int'($urandom % (T - 20));
      steady(T, typ, C);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule